// File: doc/BRIEF.md
# Programmable Interrupt Controller

This block collects up to 32 interrupt source lines for a processor core and reduces them to a single request. Two registers form its state. One is an enable register with one bit per line. The other is a pending register with one bit per line. The core reaches both registers through a small special-register port. That port has a one-bit register select, a write strobe, write data and combinational read data. A read returns the selected register in the same cycle. A write lands on the next rising clock edge.

The way pending bits are set and cleared is chosen once, at elaboration, through the `MODE` parameter. There are three choices:

- **Level mode**: the pending register simply follows the inputs, sampled each clock. No acknowledge is needed.
- **Edge mode**: a rising edge on a line sets its bit, and the bit stays set until software writes a 1 to it.
- **Legacy mode**: an input that is high sets its bit, and the bit stays set. Software clears it by writing 0 to it, so the written word acts as an AND mask.

Top module: `pic_ctrl`

## Requirements
- R1: After reset the enable register and the pending register read as all zeros, and `cpu_irq` is low.
- R2: A write with select 0 loads the enable register at the next clock edge. A read with select 0 returns the enable register in the same cycle with no wait state.
- R3: Writing all zeros to the enable register keeps `cpu_irq` low whatever the inputs do.
- R4: `cpu_irq` is high exactly when the bitwise AND of the registered pending and enable values is nonzero.
- R5: In level mode each pending bit equals its input line as sampled at the previous clock edge.
- R6: In level mode a write with select 1 has no effect on the pending register.
- R7: In edge mode a line that is high at a clock edge but was low at the edge before sets its pending bit. A set bit stays set while no clearing write reaches it. The remembered previous input is zero after reset.
- R8: In edge mode a write with select 1 clears every pending bit whose write-data bit is 1 and leaves the bits written 0 unchanged.
- R9: In edge mode, when a new rising edge and a clearing write hit the same bit at the same clock edge, the bit ends up set.
- R10: In legacy mode a line that is high at a clock edge sets its pending bit, and the bit stays set after the line falls.
- R11: In legacy mode a write with select 1 keeps only the pending bits whose write-data bit is 1. A line still high sets its bit again at the following clock edge.
- R12: A read with select 1 returns the pending register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Interrupt source lines |
| reg_sel | input | SEL_W | Register select: 0 enable, 1 pending |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Read data of the selected register, combinational |
| cpu_irq | output | 1 | Interrupt request to the core |

## Verification
The bench goes after several corner cases, each of which a wrong design would show plainly:

- **Edge racing a clear (R9).** An edge and a clearing write hit the same bit in one cycle. A design that gives the write priority loses that interrupt.
- **Reversed acknowledge polarity (R8, R11).** A design with the polarity reversed clears the wrong bits in edge mode or in legacy mode.
- **Legacy re-assertion (R11).** A legacy line held high across a clear must be pending again one cycle later. A design that blocks re-latching would hide a source that is still active.
- **Writes in level mode (R6).** Status writes are made while in level mode. A design that lets them through would show phantom or missing pending bits.
- **All-zero enable (R3).** The enable register is set to all zeros while every line is high. Any leak through the enable AND would raise `cpu_irq`.

// File: rtl/pic_pkg.sv
package pic_pkg;

   // How pending bits are set and cleared
   typedef enum logic [1:0] {
      PIC_LEVEL  = 2'd0,
      PIC_EDGE   = 2'd1,
      PIC_LEGACY = 2'd2
   } pic_mode_e;

   // Register select codes on the special-register port
   localparam int SEL_MASK = 0;
   localparam int SEL_STAT = 1;

   // Widest register word the port carries
   localparam int MAX_LINES = 32;

endpackage

// File: rtl/pic_mask_reg.sv
module pic_mask_reg #(
   parameter int NUM_LINES = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [NUM_LINES-1:0] wdata,
   output logic [NUM_LINES-1:0] mask_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_en) begin
         mask_q <= wdata;
      end
   end

endmodule

// File: rtl/pic_pending.sv
module pic_pending
   import pic_pkg::*;
#(
   parameter int        NUM_LINES = 32,
   parameter pic_mode_e MODE      = PIC_LEVEL
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] lines,
   input  logic                 wr_en,
   input  logic [NUM_LINES-1:0] wdata,
   output logic [NUM_LINES-1:0] stat_q
);

   generate
      if (MODE == PIC_LEVEL) begin : g_level
         // Pending follows the sampled inputs; writes are discarded
         logic unused_wr;
         assign unused_wr = ^{wr_en, wdata};

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stat_q <= '0;
            end else begin
               stat_q <= lines;
            end
         end
      end else if (MODE == PIC_EDGE) begin : g_edge
         logic [NUM_LINES-1:0] prev_q;
         logic [NUM_LINES-1:0] rise;
         logic [NUM_LINES-1:0] clr;

         assign rise = lines & ~prev_q;
         assign clr  = wr_en ? wdata : '0;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= '0;
               stat_q <= '0;
            end else begin
               prev_q <= lines;
               // a fresh edge outranks a clear on the same bit
               stat_q <= (stat_q & ~clr) | rise;
            end
         end
      end else begin : g_legacy
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stat_q <= '0;
            end else if (wr_en) begin
               // written word acts as an AND mask; inputs re-latch next cycle
               stat_q <= stat_q & wdata;
            end else begin
               stat_q <= stat_q | lines;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux
   import pic_pkg::*;
#(
   parameter int NUM_LINES = 32,
   parameter int SEL_W     = 1
) (
   input  logic [SEL_W-1:0]     sel,
   input  logic [NUM_LINES-1:0] mask_q,
   input  logic [NUM_LINES-1:0] stat_q,
   output logic [NUM_LINES-1:0] rdata
);

   localparam logic [SEL_W-1:0] SEL_M = SEL_W'(SEL_MASK);
   localparam logic [SEL_W-1:0] SEL_S = SEL_W'(SEL_STAT);

   always_comb begin
      if (sel == SEL_M) begin
         rdata = mask_q;
      end else if (sel == SEL_S) begin
         rdata = stat_q;
      end else begin
         rdata = '0;
      end
   end

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
   import pic_pkg::*;
#(
   parameter int        NUM_LINES = 32,
   parameter int        SEL_W     = 1,
   parameter pic_mode_e MODE      = PIC_LEVEL
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic [SEL_W-1:0]     reg_sel,
   input  logic                 reg_wr,
   input  logic [NUM_LINES-1:0] reg_wdata,
   output logic [NUM_LINES-1:0] reg_rdata,
   output logic                 cpu_irq
);

   localparam logic [SEL_W-1:0] SEL_M = SEL_W'(SEL_MASK);
   localparam logic [SEL_W-1:0] SEL_S = SEL_W'(SEL_STAT);

   generate
      if (NUM_LINES < 1 || NUM_LINES > MAX_LINES) begin : g_bad_lines
         $error("pic_ctrl: NUM_LINES out of range");
      end
      if (SEL_W < 1) begin : g_bad_sel
         $error("pic_ctrl: SEL_W must be at least 1");
      end
   endgenerate

   logic                 mask_wr;
   logic                 stat_wr;
   logic [NUM_LINES-1:0] mask_q;
   logic [NUM_LINES-1:0] stat_q;

   assign mask_wr = reg_wr && (reg_sel == SEL_M);
   assign stat_wr = reg_wr && (reg_sel == SEL_S);

   pic_mask_reg #(
      .NUM_LINES(NUM_LINES)
   ) u_mask (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (mask_wr),
      .wdata (reg_wdata),
      .mask_q(mask_q)
   );

   pic_pending #(
      .NUM_LINES(NUM_LINES),
      .MODE     (MODE)
   ) u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .lines (irq_lines),
      .wr_en (stat_wr),
      .wdata (reg_wdata),
      .stat_q(stat_q)
   );

   pic_rd_mux #(
      .NUM_LINES(NUM_LINES),
      .SEL_W    (SEL_W)
   ) u_rd (
      .sel   (reg_sel),
      .mask_q(mask_q),
      .stat_q(stat_q),
      .rdata (reg_rdata)
   );

   assign cpu_irq = |(stat_q & mask_q);

endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk
   import pic_pkg::*;
#(
   parameter int        NUM_LINES = 32,
   parameter int        SEL_W     = 1,
   parameter pic_mode_e MODE      = PIC_LEVEL
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic [SEL_W-1:0]     reg_sel,
   input logic                 reg_wr,
   input logic [NUM_LINES-1:0] reg_wdata,
   input logic [NUM_LINES-1:0] mask_q,
   input logic [NUM_LINES-1:0] stat_q,
   input logic                 cpu_irq
);

   logic wr_m;
   logic wr_s;
   assign wr_m = reg_wr && (reg_sel == SEL_W'(SEL_MASK));
   assign wr_s = reg_wr && (reg_sel == SEL_W'(SEL_STAT));

   AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      wr_m |=> mask_q == $past(reg_wdata)); // R2
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_m |=> $stable(mask_q)); // R2
   AST_MASK_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !cpu_irq); // R3
   AST_REQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> (stat_q != '0)); // R4

   generate
      if (MODE == PIC_LEVEL) begin : g_lvl
         AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> stat_q == $past(irq_lines)); // R5
      end else if (MODE == PIC_EDGE) begin : g_edg
         AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_s |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R7
         AST_EDGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            wr_s |=> (stat_q & $past(reg_wdata) & ~$past(irq_lines)) == '0); // R8
      end else begin : g_leg
         AST_LEGACY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_s |=> (stat_q & $past(stat_q)) == $past(stat_q)); // R10
         AST_LEGACY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            wr_s |=> (stat_q & ~$past(reg_wdata)) == '0); // R11
      end
   endgenerate

endmodule

bind pic_ctrl pic_ctrl_chk #(
   .NUM_LINES(NUM_LINES),
   .SEL_W    (SEL_W),
   .MODE     (MODE)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_lines(irq_lines),
   .reg_sel  (reg_sel),
   .reg_wr   (reg_wr),
   .reg_wdata(reg_wdata),
   .mask_q   (mask_q),
   .stat_q   (stat_q),
   .cpu_irq  (cpu_irq)
);

// File: tb/tb_pic_ctrl.sv
`timescale 1ns/1ps
module tb_pic_ctrl;
   import pic_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] irq_lines = '0;
   logic [0:0]  reg_sel = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rd_lvl, rd_edg, rd_leg;
   logic        irq_lvl, irq_edg, irq_leg;

   int checks = 0;
   int errors = 0;

   // expected state
   logic [31:0] e_mask = '0;
   logic [31:0] e_lvl = '0, e_edg = '0, e_leg = '0, e_prev = '0;

   always #2.5 clk = ~clk;

   pic_ctrl #(.MODE(PIC_LEVEL)) dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd_lvl), .cpu_irq(irq_lvl));
   pic_ctrl #(.MODE(PIC_EDGE)) dut_edge (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd_edg), .cpu_irq(irq_edg));
   pic_ctrl #(.MODE(PIC_LEGACY)) dut_legacy (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .reg_sel(reg_sel),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(rd_leg), .cpu_irq(irq_leg));

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   // one clock: drive, check read path and request, advance model
   task automatic step(input logic [31:0] in, input logic wr, input logic sel,
                       input logic [31:0] wd);
      logic [31:0] n_mask, n_lvl, n_edg, n_leg;
      irq_lines = in; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
      #1;
      if (sel == 1'b0) begin
         chk("R2 enable read level", rd_lvl, e_mask);
         chk("R2 enable read edge", rd_edg, e_mask);
         chk("R2 enable read legacy", rd_leg, e_mask);
      end else begin
         chk("R5 pending read level", rd_lvl, e_lvl);
         chk("R7 pending read edge", rd_edg, e_edg);
         chk("R10 pending read legacy", rd_leg, e_leg);
      end
      chk("R4 request level", {31'd0, irq_lvl}, {31'd0, |(e_lvl & e_mask)});
      chk("R4 request edge", {31'd0, irq_edg}, {31'd0, |(e_edg & e_mask)});
      chk("R4 request legacy", {31'd0, irq_leg}, {31'd0, |(e_leg & e_mask)});
      n_mask = (wr && !sel) ? wd : e_mask;
      n_lvl  = in;
      n_edg  = ((wr && sel) ? (e_edg & ~wd) : e_edg) | (in & ~e_prev);
      n_leg  = (wr && sel) ? (e_leg & wd) : (e_leg | in);
      @(posedge clk);
      e_mask = n_mask; e_lvl = n_lvl; e_edg = n_edg; e_leg = n_leg; e_prev = in;
      @(negedge clk);
   endtask

   task automatic peek_stat();
      reg_wr = 1'b0; reg_sel = 1'b1;
      #1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd7177));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: reset state
      chk("R1 enable after reset", rd_lvl, 32'h0);
      peek_stat();
      chk("R1 pending after reset level", rd_lvl, 32'h0);
      chk("R1 pending after reset edge", rd_edg, 32'h0);
      chk("R1 pending after reset legacy", rd_leg, 32'h0);
      chk("R1 request after reset", {29'd0, irq_lvl, irq_edg, irq_leg}, 32'h0);
      @(negedge clk);

      step(32'h0, 1'b1, 1'b0, 32'hFFFF_FFFF);
      step(32'h0000_0011, 1'b0, 1'b1, 32'h0);
      // R6 R8 R11: write to pending with line 0 still high
      step(32'h0000_0001, 1'b1, 1'b1, 32'h0000_0010);
      peek_stat();
      chk("R6 level ignores write", rd_lvl, 32'h0000_0001);
      chk("R8 edge clears written ones", rd_edg, 32'h0000_0001);
      chk("R11 legacy keeps written ones", rd_leg, 32'h0000_0010);
      step(32'h0000_0100, 1'b0, 1'b1, 32'h0);
      step(32'h0000_0000, 1'b0, 1'b1, 32'h0);
      peek_stat();
      chk("R12 pending read level", rd_lvl, 32'h0);
      chk("R7 edge stays set", rd_edg, 32'h0000_0101);
      chk("R10 legacy stays latched", rd_leg, 32'h0000_0110);
      // R9: new edge on bit 1 together with a clear of bit 1
      step(32'h0000_0002, 1'b1, 1'b1, 32'h0000_0103);
      peek_stat();
      chk("R9 edge beats clear", rd_edg, 32'h0000_0002);
      chk("R11 legacy and-mask", rd_leg, 32'h0000_0100);
      // R11: clear all with line 8 held high, then it returns
      step(32'h0000_0100, 1'b1, 1'b1, 32'h0);
      peek_stat();
      chk("R11 legacy cleared", rd_leg, 32'h0);
      step(32'h0000_0100, 1'b0, 1'b1, 32'h0);
      peek_stat();
      chk("R11 legacy re-latched", rd_leg, 32'h0000_0100);
      // R3: enable all zero blocks every line
      step(32'hFFFF_FFFF, 1'b1, 1'b0, 32'h0);
      step(32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0);
      chk("R3 zero enable quiet", {29'd0, irq_lvl, irq_edg, irq_leg}, 32'h0);
      step(32'h0, 1'b1, 1'b0, 32'h8000_0001);

      for (int i = 0; i < 800; i++) begin
         logic [31:0] in_v;
         logic [31:0] wd_v;
         in_v = $urandom & $urandom;
         wd_v = ($urandom % 4 == 0) ? 32'h0 : $urandom;
         step(in_v, ($urandom % 3) == 0, $urandom % 2 == 1, wd_v);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule